// File: doc/BRIEF.md
# Protected Power Mode Controller

This block manages the power states of an 8-bit microcontroller core. The CPU writes a power control register through a simple write port and can read it back at any time. The block then drives the clock enables for the rest of the chip: a CPU clock enable, a peripheral clock enable, an oscillator enable and a divide-by-8 rate select. It also watches an instruction-retire strobe, a peripheral interrupt request, an active-low external wake pin and reset.

Idle and power-down are guarded. Software must write an arming bit on one instruction and the matching confirming bit on the next write. If any instruction retires in between, the arming is lost. Slow-down takes a single write. In slow-down, both clock enables pulse once in every eight cycles, driven by a 3-bit counter rather than a derived clock. Slow-down can be combined with idle, so the peripherals keep running at the reduced rate while the CPU is stopped.

Power-down is left through an asynchronously set wake flag. That flag turns the oscillator back on at once, and a two-flop synchronizer then returns the state machine to normal run.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, osc_en and both clock enables are high on every cycle, and div8_sel is low.
- R2: Idle is entered by two writes. The first write has bit 0 set. The second write, with no retire strobe between them, has bit 5 set. In idle, cpu_clk_en is low, periph_clk_en stays high, and rd_data reads 0x21.
- R3: Power-down is entered by two writes. The first write has bit 1 set. The second write, with no retire strobe between them, has bit 6 set. In power-down, osc_en, cpu_clk_en and periph_clk_en are all low, rd_data bits 1 and 6 read 1, and the other register bits keep their values.
- R4: Writing bit 4 as 1 selects slow-down. div8_sel goes high, and both clock enables are high on exactly one cycle in eight. The first such cycle is the eighth cycle after the write. Writing bit 4 as 0 restores full rate.
- R5: An arming bit (bit 0 or bit 1) reads 1 only until the next retire strobe that comes without a write. After that strobe, a confirming write enters no mode, and the bit reads 0.
- R6: A confirming bit (5 or 6) written while its sequence is not armed enters no mode. This includes a single write that sets both bits of a pair, such as 0x21 or 0x42. Bits 5 and 6 read 0 after such a write.
- R7: In idle, a high periph_irq at a clock edge returns the block to run. Bits 0 and 5 clear, and bit 4 is kept.
- R8: Writing 0x01 and then 0x30 enters idle with slow-down. cpu_clk_en stays low, periph_clk_en is high on one cycle in eight, and rd_data reads 0x31.
- R9: In power-down, a low level on ext_wake_n raises osc_en without waiting for a clock edge. The block is back in run within three clock edges, with bits 1 and 6 cleared and bit 4 kept.
- R10: periph_irq has no effect in run or power-down. ext_wake_n low has no effect in run or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken only in run |
| wr_data | input | 8 | Value written to the power control register |
| instr_retire | input | 1 | One pulse per retired instruction |
| periph_irq | input | 1 | Enabled peripheral interrupt request |
| ext_wake_n | input | 1 | Active-low external wake pin |
| rd_data | output | 8 | Power control register read value |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| div8_sel | output | 1 | Divide-by-8 rate selected |

## Verification
The bench targets a retire strobe that falls between the two writes of a pair. A design that ignored it would enter idle or power-down after an unrelated instruction. It also writes both bits of a pair in one write. A design that accepted this would drop into a mode on a single stray write.

The bench checks the phase of the slow-down divider right after bit 4 is set, so a counter that was not cleared would pulse early. It checks that bit 4 survives idle and power-down exits, which catches a design that clears the whole register on wake. It checks that osc_en rises before any clock edge once the wake pin falls, which catches a wake path that waits on the stopped clock.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       instr_retire,
  input  logic       periph_irq,
  input  logic       ext_wake_n,
  output logic [7:0] rd_data,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       div8_sel
);
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_PDN} mode_t;
  mode_t mode;

  logic arm_idle, arm_pdn, slow;
  logic [DIV_W-1:0] div_cnt;
  logic wake_flag;
  logic [1:0] wake_sync;

  wire in_run  = (mode == ST_RUN);
  wire in_idle = (mode == ST_IDLE);
  wire in_pdn  = (mode == ST_PDN);
  wire wr_ok   = wr_en && in_run;
  wire go_pdn  = wr_ok && arm_pdn && wr_data[6];
  wire go_idle = wr_ok && arm_idle && wr_data[5] && !go_pdn;
  wire rate_en = !slow || (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= ST_RUN;
      arm_idle <= 1'b0;
      arm_pdn  <= 1'b0;
      slow     <= 1'b0;
    end else begin
      case (mode)
        ST_RUN: begin
          if (wr_ok) begin
            slow     <= wr_data[4];
            arm_idle <= wr_data[0] && !go_idle && !go_pdn;
            arm_pdn  <= wr_data[1] && !go_idle && !go_pdn;
            if (go_pdn)       mode <= ST_PDN;
            else if (go_idle) mode <= ST_IDLE;
          end else if (instr_retire) begin
            arm_idle <= 1'b0;
            arm_pdn  <= 1'b0;
          end
        end
        ST_IDLE: if (periph_irq)   mode <= ST_RUN;
        ST_PDN:  if (wake_sync[1]) mode <= ST_RUN;
        default: mode <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   div_cnt <= '0;
    else if (wr_ok && wr_data[4] && !slow) div_cnt <= '0;
    else if (!in_pdn)             div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n or negedge ext_wake_n) begin
    if (!rst_n)                      wake_flag <= 1'b0;
    else if (!ext_wake_n && in_pdn)  wake_flag <= 1'b1;
    else if (!in_pdn)                wake_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_sync <= 2'b00;
    else        wake_sync <= in_pdn ? {wake_sync[0], wake_flag} : 2'b00;
  end

  assign cpu_clk_en    = in_run && rate_en;
  assign periph_clk_en = !in_pdn && rate_en;
  assign osc_en        = !in_pdn || wake_flag;
  assign div8_sel      = slow;
  assign rd_data = {1'b0, in_pdn, in_idle, slow, 2'b00,
                    arm_pdn || in_pdn, arm_idle || in_idle};

  AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && $past(mode) == ST_RUN) |-> $past(arm_idle));  // R2
  AST_PDN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pdn && $past(mode) == ST_RUN) |-> $past(arm_pdn));  // R3
  AST_ARM_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !wr_en && instr_retire) |=> (rd_data[1:0] == 2'b00));  // R5
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && periph_irq) |=> cpu_clk_en || div8_sel);  // R7
  AST_SLOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_run |=> $stable(div8_sel));  // R4
  AST_PDN_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[6]) |-> (!cpu_clk_en && !periph_clk_en));  // R3
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n, wr_en, instr_retire, periph_irq, ext_wake_n;
  logic [7:0] wr_data, rd_data;
  logic cpu_clk_en, periph_clk_en, osc_en, div8_sel;

  always #2 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .instr_retire(instr_retire), .periph_irq(periph_irq), .ext_wake_n(ext_wake_n),
    .rd_data(rd_data), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .div8_sel(div8_sel));

  typedef struct { string req; logic [9:0] exp; } item_t;
  item_t sb[$];
  item_t cur;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      check(cur.req, {rd_data, osc_en, div8_sel}, cur.exp);
    end
  end

  task automatic expect_state(string r, logic [7:0] rd, logic osc, logic dv);
    item_t it;
    it.req = r;
    it.exp = {rd, osc, dv};
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic retire();
    instr_retire = 1'b1;
    @(negedge clk);
    instr_retire = 1'b0;
  endtask

  task automatic irq_pulse();
    periph_irq = 1'b1;
    @(negedge clk);
    periph_irq = 1'b0;
  endtask

  task automatic measure(string r, int exp_cpu, int exp_per);
    int c = 0, p = 0;
    repeat (8) begin
      #1;
      c += int'(cpu_clk_en);
      p += int'(periph_clk_en);
      @(negedge clk);
    end
    check({r, " cpu_en count"}, c, exp_cpu);
    check({r, " periph_en count"}, p, exp_per);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; instr_retire = 0; periph_irq = 0; ext_wake_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_state("R1", 8'h00, 1, 0);
    measure("R1", 8, 8);
    // R10 interrupt in run ignored
    irq_pulse();
    expect_state("R10 irq in run", 8'h00, 1, 0);
    // R2 idle entry
    wr(8'h01); wr(8'h20);
    expect_state("R2", 8'h21, 1, 0);
    measure("R2", 0, 8);
    // R10 wake pin in idle ignored
    ext_wake_n = 0; @(negedge clk); ext_wake_n = 1;
    measure("R10 pin in idle", 0, 8);
    // R7 idle exit
    irq_pulse();
    expect_state("R7", 8'h00, 1, 0);
    measure("R7", 8, 8);
    // R5 arming lost after a retire
    wr(8'h01);
    expect_state("R5 armed", 8'h01, 1, 0);
    retire(); wr(8'h20);
    expect_state("R5 idle", 8'h00, 1, 0);
    measure("R5", 8, 8);
    wr(8'h02); retire(); wr(8'h40);
    expect_state("R5 pdn", 8'h00, 1, 0);
    // R6 same-write and unarmed confirm
    wr(8'h21);
    expect_state("R6 both idle bits", 8'h01, 1, 0);
    retire();
    expect_state("R6 after retire", 8'h00, 1, 0);
    wr(8'h42);
    expect_state("R6 both pdn bits", 8'h02, 1, 0);
    retire();
    wr(8'h20);
    expect_state("R6 lone confirm", 8'h00, 1, 0);
    // R4 slow-down phase
    wr(8'h10);
    begin
      int early = 0;
      repeat (7) begin #1; early += int'(cpu_clk_en); @(negedge clk); end
      check("R4 no enable before 8th cycle", early, 0);
      #1; check("R4 enable on 8th cycle", int'(cpu_clk_en), 1);
      @(negedge clk);
    end
    expect_state("R4", 8'h10, 1, 1);
    measure("R4", 1, 1);
    wr(8'h00);
    expect_state("R4 cleared", 8'h00, 1, 0);
    measure("R4 cleared", 8, 8);
    // R8 idle with slow-down
    wr(8'h01); wr(8'h30);
    expect_state("R8", 8'h31, 1, 1);
    measure("R8", 0, 1);
    irq_pulse();
    expect_state("R7 slow kept", 8'h10, 1, 1);
    measure("R7 slow run", 1, 1);
    // R3 power-down with slow kept
    wr(8'h12); wr(8'h50);
    expect_state("R3", 8'h52, 0, 1);
    measure("R3", 0, 0);
    irq_pulse();
    expect_state("R10 irq in pdn", 8'h52, 0, 1);
    // R9 wake
    #1 ext_wake_n = 0;
    #0.5 check("R9 osc_en async", int'(osc_en), 1);
    @(negedge clk); ext_wake_n = 1;
    repeat (3) @(negedge clk);
    expect_state("R9", 8'h10, 1, 1);
    measure("R9", 1, 1);
    wr(8'h00);
    expect_state("R9 final", 8'h00, 1, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule